// File: doc/BRIEF.md
# Multi-mode Crypto Command Sequencer

This block is the host-facing controller of a compact crypto engine. It accepts one command at a time. Each command drives an external 96-bit block cipher through a request/acknowledge port. It supports three operations over that one cipher:

- a double-length hash that turns 48-bit message blocks into a 192-bit digest;
- block encryption in either independent-block or chained-block form;
- a counter-driven pseudo-random generator.

The host starts an operation with a one-cycle `start` pulse. At that pulse the block samples the mode, the chaining choice, the key and the initial value. A fresh key and initial value are therefore taken for every operation, and nothing from an earlier operation is carried over except the generator counter. When the block needs a data block it emits a one-cycle `next_blk` pulse, and the host answers with `blk_valid`. The block signals a result with a one-cycle `done` pulse. The result port carries data only in that cycle, so internal state cannot be observed at any other time.

Top module: `crypto_cmd_seq`

## Requirements
- R1: `mode` selects the operation: 1 = hash, 2 = encryption, 3 = random generation. A `start` with mode 0 is ignored, and the block stays idle with no request, pulse or result.
- R2: `mode`, `chain_en`, `key_in` and `iv_in` are sampled only on an accepted `start`. While an operation runs, a further `start` and any change on these inputs have no effect on its results.
- R3: The hash loads both 96-bit chaining values G and H from `iv_in`. For each message block m (taken from `data_in[47:0]`, upper bits ignored), the cipher key is {m, H}, with m in key bits 143:96. The update is H' = E(G ^ C) ^ G ^ C and G' = E(G) ^ G, where C is all ones.
- R4: The hash ends after the block accepted with `blk_last` = 1. `done` then presents the digest with G on `dout[95:0]` and H on `dout[191:96]`.
- R5: `next_blk` is a one-cycle pulse each time a block is wanted. The block is taken on the first later cycle with `blk_valid` = 1.
- R6: In encryption with `chain_en` = 0, each block yields `done` with `dout[95:0]` = E({48'b0, key}, data) and `dout[191:96]` = 0. Blocks continue until one is given with `blk_last` = 1.
- R7: In encryption with `chain_en` = 1, each block is XORed before encryption with the previous ciphertext, or with `iv_in` for the first block.
- R8: Each random-generation command yields one block, E({48'b0, key}, {74'b0, count}), on `dout[95:0]`. The 22-bit count is zero after reset, advances by one per block (modulo 2^22), and persists across commands of all modes.
- R9: `dout` is all zeros in every cycle where `done` is low.
- R10: `cph_req` stays high with stable `cph_key` and `cph_pt` until `cph_ack`. `cph_wide` is high for hash requests only, and narrow requests carry zeros in `cph_key[143:96]`.
- R11: `done` lasts one cycle. `next_blk`, `done` and `cph_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command pulse |
| mode | input | 2 | Operation select |
| chain_en | input | 1 | Chained encryption when high |
| key_in | input | 96 | Cipher key for encryption and random generation |
| iv_in | input | 96 | Initial chaining value |
| data_in | input | 96 | Data block (hash uses low 48 bits) |
| blk_valid | input | 1 | Host presents a block |
| blk_last | input | 1 | Presented block is the final one |
| next_blk | output | 1 | Block wanted (one-cycle pulse) |
| done | output | 1 | Result valid (one-cycle pulse) |
| dout | output | 192 | Result, zero unless done |
| cph_req | output | 1 | Cipher request |
| cph_wide | output | 1 | Request uses 144-bit key |
| cph_key | output | 144 | Cipher key |
| cph_pt | output | 96 | Cipher input block |
| cph_ack | input | 1 | Cipher result ready |
| cph_ct | input | 96 | Cipher output block |

## Verification
A corrupted chaining value or key register does not show up until the next `done`. For the hash this is only the final digest, but a single wrong bit spreads through the cipher into roughly half of that digest. In chained encryption, a wrong chain register corrupts the current ciphertext and every later one. A stale generator counter shows as a repeated or unexpected block on the next command. A control fault shows at once at the ports: a stretched pulse, overlapping handshake signals, or nonzero `dout` outside `done`.

// File: rtl/crypto_cmd_seq.sv
module crypto_cmd_seq #(
  parameter int BLK_W = 96,
  parameter int CNT_W = 22,
  parameter logic [BLK_W-1:0] HCONST = '1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [1:0]             mode,
  input  logic                   chain_en,
  input  logic [BLK_W-1:0]       key_in,
  input  logic [BLK_W-1:0]       iv_in,
  input  logic [BLK_W-1:0]       data_in,
  input  logic                   blk_valid,
  input  logic                   blk_last,
  output logic                   next_blk,
  output logic                   done,
  output logic [2*BLK_W-1:0]     dout,
  output logic                   cph_req,
  output logic                   cph_wide,
  output logic [BLK_W*3/2-1:0]   cph_key,
  output logic [BLK_W-1:0]       cph_pt,
  input  logic                   cph_ack,
  input  logic [BLK_W-1:0]       cph_ct
);
  localparam int MSG_W = BLK_W / 2;
  localparam logic [1:0] M_HASH = 2'd1;
  localparam logic [1:0] M_ENC  = 2'd2;
  localparam logic [1:0] M_RNG  = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_ASK, S_WAIT, S_RQ1, S_RQ2, S_FIN} st_t;

  st_t              st;
  logic [1:0]       md;
  logic             chn, last_r;
  logic [BLK_W-1:0] key_r, g_r, h_r, blk_r, t_r;
  logic [CNT_W-1:0] cnt_r;
  logic [BLK_W-1:0] blk_nx;
  logic             idle;

  assign idle     = (st == S_IDLE);
  assign next_blk = (st == S_ASK);
  assign done     = (st == S_FIN);
  assign cph_req  = (st == S_RQ1) || (st == S_RQ2);
  assign cph_wide = (md == M_HASH);

  assign blk_nx = (md == M_HASH) ? {{MSG_W{1'b0}}, data_in[MSG_W-1:0]}
                : (chn ? (data_in ^ g_r) : data_in);

  assign cph_key = (md == M_HASH) ? {blk_r[MSG_W-1:0], h_r}
                                  : {{MSG_W{1'b0}}, key_r};

  always_comb begin
    if (st == S_RQ2)        cph_pt = g_r;
    else if (md == M_HASH)  cph_pt = g_r ^ HCONST;
    else if (md == M_ENC)   cph_pt = blk_r;
    else                    cph_pt = {{(BLK_W-CNT_W){1'b0}}, cnt_r};
  end

  always_comb begin
    dout = '0;
    if (done) dout = (md == M_HASH) ? {h_r, g_r} : {{BLK_W{1'b0}}, t_r};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      md     <= '0;
      chn    <= 1'b0;
      last_r <= 1'b0;
      key_r  <= '0;
      g_r    <= '0;
      h_r    <= '0;
      blk_r  <= '0;
      t_r    <= '0;
      cnt_r  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start && mode != 2'd0) begin
          md     <= mode;
          chn    <= chain_en;
          key_r  <= key_in;
          g_r    <= iv_in;
          h_r    <= iv_in;
          last_r <= (mode == M_RNG);
          st     <= (mode == M_RNG) ? S_RQ1 : S_ASK;
        end
        S_ASK: st <= S_WAIT;
        S_WAIT: if (blk_valid) begin
          last_r <= blk_last;
          blk_r  <= blk_nx;
          st     <= S_RQ1;
        end
        S_RQ1: if (cph_ack) begin
          t_r <= cph_ct;
          if (md == M_HASH) st <= S_RQ2;
          else begin
            st <= S_FIN;
            if (md == M_ENC) g_r <= cph_ct;
            else             cnt_r <= cnt_r + 1'b1;
          end
        end
        S_RQ2: if (cph_ack) begin
          g_r <= cph_ct ^ g_r;
          h_r <= t_r ^ g_r ^ HCONST;
          st  <= last_r ? S_FIN : S_ASK;
        end
        S_FIN: st <= last_r ? S_IDLE : S_ASK;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/crypto_cmd_seq_chk.sv
module crypto_cmd_seq_chk #(
  parameter int BLK_W = 96
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic [1:0]           mode,
  input logic                 idle,
  input logic                 next_blk,
  input logic                 done,
  input logic [2*BLK_W-1:0]   dout,
  input logic                 cph_req,
  input logic                 cph_wide,
  input logic [BLK_W*3/2-1:0] cph_key,
  input logic [BLK_W-1:0]     cph_pt,
  input logic                 cph_ack
);
  localparam int MSG_W = BLK_W / 2;

  a_r1_mode0_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start && mode == 2'd0) |=> idle);

  a_r5_next_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    next_blk |=> !next_blk);

  a_r9_dout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (dout == '0));

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cph_req && !cph_ack) |=> (cph_req && $stable(cph_key) && $stable(cph_pt)));

  a_r10_narrow_key: assert property (@(posedge clk) disable iff (!rst_n)
    (cph_req && !cph_wide) |-> (cph_key[BLK_W+MSG_W-1:BLK_W] == '0));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({next_blk, done, cph_req}));
endmodule

bind crypto_cmd_seq crypto_cmd_seq_chk #(.BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .idle(idle),
  .next_blk(next_blk), .done(done), .dout(dout), .cph_req(cph_req),
  .cph_wide(cph_wide), .cph_key(cph_key), .cph_pt(cph_pt), .cph_ack(cph_ack)
);

// File: tb/crypto_cmd_seq_tb.sv
`timescale 1ns/1ps
module crypto_cmd_seq_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   mode = '0;
  logic         chain_en = 1'b0;
  logic [95:0]  key_in = '0, iv_in = '0, data_in = '0;
  logic         blk_valid = 1'b0, blk_last = 1'b0;
  logic         next_blk, done, cph_req, cph_wide, cph_ack;
  logic [191:0] dout;
  logic [143:0] cph_key;
  logic [95:0]  cph_pt, cph_ct;
  logic [2:0]   lat_c;

  int checks = 0, fails = 0, cyc = 0, r9_bad = 0;
  localparam logic [95:0] HC = '1;

  always #2.5 clk = ~clk;

  crypto_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .chain_en(chain_en),
    .key_in(key_in), .iv_in(iv_in), .data_in(data_in), .blk_valid(blk_valid),
    .blk_last(blk_last), .next_blk(next_blk), .done(done), .dout(dout),
    .cph_req(cph_req), .cph_wide(cph_wide), .cph_key(cph_key), .cph_pt(cph_pt),
    .cph_ack(cph_ack), .cph_ct(cph_ct)
  );

  function automatic logic [95:0] perm(input logic [143:0] k, input logic [95:0] p);
    logic [95:0] x;
    x = p;
    for (int r = 0; r < 6; r++)
      x = {x[94:0], x[95]} ^ (x & {x[7:0], x[95:8]}) ^ k[95:0]
          ^ {k[143:96], k[143:96]} ^ 96'(r + 1);
    return x;
  endfunction

  function automatic logic [95:0] mk(input int s, input int i);
    return {32'(s * 1103515245 + i), 32'(i * 7919 + s), 32'(s ^ (i << 4))};
  endfunction

  always_ff @(posedge clk)
    if (!rst_n || !cph_req || cph_ack) lat_c <= '0;
    else lat_c <= lat_c + 3'd1;
  assign cph_ack = cph_req && (lat_c == 3'd2);
  assign cph_ct  = perm(cph_key, cph_pt);

  always @(negedge clk)
    if (rst_n && !done && dout != '0) r9_bad++;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=<100000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic go(input logic [1:0] m, input bit c, input logic [95:0] k, input logic [95:0] iv);
    @(negedge clk);
    mode = m; chain_en = c; key_in = k; iv_in = iv; start = 1'b1;
    @(negedge clk);
    start = 1'b0; key_in = ~k; iv_in = ~iv; mode = 2'd3; chain_en = ~c;
  endtask

  task automatic wait_next(input string req);
    bit ok = 0;
    for (int i = 0; i < 300; i++) begin
      if (next_blk) begin ok = 1; break; end
      @(negedge clk);
    end
    chk(ok, req, 192'(next_blk), 192'd1);
  endtask

  task automatic feed(input logic [95:0] d, input bit last, input bit inj);
    @(negedge clk);
    chk(!next_blk, "R5 pulse width", 192'(next_blk), 192'd0);
    data_in = d; blk_valid = 1'b1; blk_last = last;
    if (inj) begin start = 1'b1; mode = 2'd2; iv_in = mk(99, 1); key_in = mk(98, 2); end
    @(negedge clk);
    blk_valid = 1'b0; blk_last = 1'b0; data_in = ~d; start = 1'b0;
  endtask

  task automatic wait_done(output logic [191:0] v);
    bit ok = 0;
    v = '0;
    for (int i = 0; i < 300; i++) begin
      if (done) begin ok = 1; v = dout; break; end
      @(negedge clk);
    end
    if (!ok) chk(0, "done timeout", 192'(done), 192'd1);
  endtask

  task automatic t_reset;
    chk(!next_blk && !done && !cph_req, "R11 reset idle", {next_blk, done, cph_req}, '0);
    chk(dout == '0, "R9 reset dout", dout, '0);
  endtask

  task automatic t_prng(input logic [95:0] k, input int cnt);
    logic [191:0] v, e;
    go(2'd3, 1'b0, k, mk(5, cnt));
    wait_done(v);
    e = {96'b0, perm({48'b0, k}, {74'b0, 22'(cnt)})};
    chk(v == e, "R8 prng block", v, e);
  endtask

  task automatic t_hash(input int n, input int s, input bit inj);
    logic [95:0] g, h, t, gn, d;
    logic [143:0] k;
    logic [191:0] v;
    g = mk(s, 77); h = g;
    go(2'd1, 1'b0, mk(s, 55), g);
    for (int i = 0; i < n; i++) begin
      d = mk(s, i);
      k = {d[47:0], h};
      t = perm(k, g ^ HC);
      gn = perm(k, g) ^ g;
      h = t ^ g ^ HC;
      g = gn;
      wait_next("R5 hash next_blk");
      feed(d, i == n - 1, inj && i == 0);
    end
    wait_done(v);
    chk(v == {h, g}, inj ? "R2 hash busy start" : "R3 R4 hash digest", v, {h, g});
  endtask

  task automatic t_enc(input bit cbc, input int s, input int n);
    logic [95:0] k, chain, d, ct;
    logic [191:0] v;
    k = mk(s, 3); chain = mk(s, 4);
    go(2'd2, cbc, k, chain);
    for (int i = 0; i < n; i++) begin
      d = mk(s, i >> 1);
      ct = perm({48'b0, k}, cbc ? (d ^ chain) : d);
      chain = ct;
      wait_next("R5 enc next_blk");
      feed(d, i == n - 1, 1'b0);
      wait_done(v);
      chk(v == {96'b0, ct}, cbc ? "R7 cbc block" : "R6 ecb block", v, {96'b0, ct});
    end
  endtask

  task automatic t_mode0;
    bit seen = 0;
    go(2'd0, 1'b0, mk(1, 1), mk(1, 2));
    for (int i = 0; i < 30; i++) begin
      if (next_blk || done || cph_req) seen = 1;
      @(negedge clk);
    end
    chk(!seen, "R1 mode 0 ignored", 192'(seen), 192'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prng(mk(7, 0), 0);
    t_prng(mk(7, 1), 1);
    t_hash(1, 11, 1'b0);
    t_hash(3, 12, 1'b0);
    t_hash(2, 13, 1'b1);
    t_enc(1'b0, 21, 4);
    t_enc(1'b1, 22, 4);
    t_mode0();
    t_prng(mk(7, 2), 2);
    chk(r9_bad == 0, "R9 dout quiet", 192'(r9_bad), 192'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule